// File: doc/BRIEF.md
# Switchable Three-Tap Deconvolution Filter

This block sits on the digital side of one silicon-strip readout channel. It receives one digitized sample per bunch crossing of a pulse that has passed through a slow 50 ns CR-RC shaper. For every new sample it forms a weighted sum of that sample and the two samples before it. The weights undo the shaper's long tail, so a single charge deposit gives a single large output in one crossing slot, with near-zero outputs in the slots around it.

The weights are not programmable. Two fixed sets are built in, one matched to a 20 MHz crossing rate and one to 40 MHz. A one-bit select input chooses the set at run time, and both sets share the same multiply-add datapath. Each weight is stored as a signed fixed-point value scaled by 256. The sum is scaled back down with round-half-up and limited to a signed 10-bit result.

Top module: `deconv3_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `out_valid` = 0 and `out_sample` = 0.
- R2: With `xrate_sel` = 0 (20 MHz), a valid output equals round(256·s[n] − 189·s[n−1] + 36·s[n−2]) / 256, where s[n] is the newest sample and samples are unsigned 8-bit values.
- R3: With `xrate_sel` = 1 (40 MHz), a valid output equals round(256·s[n] − 310·s[n−1] + 95·s[n−2]) / 256.
- R4: The division by 256 rounds half up, that is floor((acc + 128) / 256). An exact half therefore goes toward positive infinity for both signs (5.5 → 6, −94.5 → −94).
- R5: A result appears with `out_valid` high exactly one clock after the edge that accepts the sample completing its window, and `out_valid` is high for that single cycle only.
- R6: After reset, `out_valid` stays low for the first two accepted samples and goes high for the third.
- R7: A change of `xrate_sel` restarts the window. The sample accepted in the cycle of the change counts as the first new sample, and no output is produced until three samples have been accepted under the new setting.
- R8: Cycles with `in_valid` low neither shift the sample history nor produce an output. The next valid sample is combined with the two samples accepted before the gap.
- R9: The accumulator never overflows, and the output is saturated to the signed range −512..511.
- R10: For a sampled ideal CR-RC pulse, in either mode, the filtered response is concentrated in one slot. Every other output has a magnitude of at most one eighth of the peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| xrate_sel | input | 1 | Crossing-rate select: 0 = 20 MHz weights, 1 = 40 MHz weights |
| in_valid | input | 1 | Marks `in_sample` as a new sample this cycle |
| in_sample | input | 8 | Unsigned digitized shaper sample |
| out_valid | output | 1 | Marks `out_sample` as a new filtered value |
| out_sample | output | 10 | Signed filtered result, two's complement |

## Verification
A table of three-sample windows checks the weighted sum in both modes. The flat windows tell the two weight sets apart, and the single-spike windows isolate each tap weight on its own. Two windows fall exactly on a half step of opposite sign, which separates round-half-up from truncation and from round-half-away-from-zero. A sampled ideal CR-RC pulse, spaced 50 ns in one mode and 25 ns in the other, is compared slot by slot against a model computed in the bench and checked for concentration in one slot; this catches a weight set that is mismatched to its rate. Directed sequences cover the warm-up after reset, gaps in `in_valid`, and a mode change in the middle of a stream, which tell correct window bookkeeping apart from off-by-one shifting.

// File: rtl/deconv3_pkg.sv
package deconv3_pkg;

    localparam int SAMPLE_W = 8;
    localparam int COEF_W   = 10;
    localparam int FRAC_W   = 8;
    localparam int OUT_W    = 10;
    localparam int HIST_N   = 2;
    localparam int ACC_W    = SAMPLE_W + COEF_W + 2;

    typedef enum logic {
        XR_20MHZ = 1'b0,
        XR_40MHZ = 1'b1
    } xrate_e;

    typedef logic signed [COEF_W-1:0] coef_t;

    // weight applied to newest, one-back and two-back sample
    typedef struct packed {
        coef_t cur;
        coef_t prev1;
        coef_t prev2;
    } tapw_t;

    localparam tapw_t W_20MHZ = '{cur: coef_t'(256), prev1: coef_t'(-189), prev2: coef_t'(36)};
    localparam tapw_t W_40MHZ = '{cur: coef_t'(256), prev1: coef_t'(-310), prev2: coef_t'(95)};

    function automatic tapw_t weights_for(xrate_e r);
        return (r == XR_40MHZ) ? W_40MHZ : W_20MHZ;
    endfunction

    function automatic logic signed [ACC_W-1:0] term(logic [SAMPLE_W-1:0] s, coef_t c);
        logic signed [ACC_W-1:0] se;
        logic signed [ACC_W-1:0] ce;
        se = $signed(ACC_W'(s));
        ce = ACC_W'(c);
        return se * ce;
    endfunction

    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0] OUT_MAX  = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] OUT_MIN  = ACC_W'(-(1 << (OUT_W - 1)));

    function automatic logic signed [OUT_W-1:0] round_sat(logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] r;
        r = (acc + HALF_LSB) >>> FRAC_W;
        if (r > OUT_MAX)      return {1'b0, {(OUT_W-1){1'b1}}};
        else if (r < OUT_MIN) return {1'b1, {(OUT_W-1){1'b0}}};
        else                  return r[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/deconv3_window.sv
module deconv3_window
    import deconv3_pkg::*;
#(
    parameter int SW    = SAMPLE_W,
    parameter int DEPTH = HIST_N
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  logic                      restart,
    input  logic [SW-1:0]             din,
    output logic [DEPTH-1:0][SW-1:0]  hist,
    output logic                      full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SW-1:0]    stage_q [DEPTH];
    logic [CNT_W-1:0] fill_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[g] <= '0;
            else if (shift_en)
                stage_q[g] <= (g == 0) ? din : stage_q[(g == 0) ? 0 : g - 1];
        end
        assign hist[g] = stage_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            fill_q <= '0;
        else if (restart)
            fill_q <= shift_en ? CNT_W'(1) : '0;
        else if (shift_en && !full)
            fill_q <= fill_q + CNT_W'(1);
    end

    assign full = (fill_q == CNT_W'(DEPTH));

    // R6
    fill_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(shift_en));

endmodule

// File: rtl/deconv3_coefs.sv
module deconv3_coefs
    import deconv3_pkg::*;
(
    input  xrate_e sel,
    output tapw_t  w
);
    assign w = weights_for(sel);
endmodule

// File: rtl/deconv3_mac.sv
module deconv3_mac
    import deconv3_pkg::*;
(
    input  logic [SAMPLE_W-1:0]             newest,
    input  logic [HIST_N-1:0][SAMPLE_W-1:0] hist,
    input  tapw_t                           w,
    output logic signed [ACC_W-1:0]         acc,
    output logic signed [OUT_W-1:0]         y
);
    always_comb begin
        acc = term(newest, w.cur) + term(hist[0], w.prev1) + term(hist[1], w.prev2);
        y   = round_sat(acc);
    end
endmodule

// File: rtl/deconv3_filter.sv
module deconv3_filter
    import deconv3_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      xrate_sel,
    input  logic                      in_valid,
    input  logic [SAMPLE_W-1:0]       in_sample,
    output logic                      out_valid,
    output logic signed [OUT_W-1:0]   out_sample
);
    localparam int ACC_BOUND = ((1 << SAMPLE_W) - 1) * 700;

    xrate_e                          rate;
    xrate_e                          rate_q;
    logic                            restart;
    logic                            full;
    logic                            fire;
    logic [HIST_N-1:0][SAMPLE_W-1:0] hist;
    tapw_t                           w;
    logic signed [ACC_W-1:0]         acc;
    logic signed [OUT_W-1:0]         y;

    assign rate    = xrate_e'(xrate_sel);
    assign restart = (rate != rate_q);
    assign fire    = in_valid && full && !restart;

    always_ff @(posedge clk) begin
        if (rst) rate_q <= XR_20MHZ;
        else     rate_q <= rate;
    end

    deconv3_window #(.SW(SAMPLE_W), .DEPTH(HIST_N)) u_window (
        .clk(clk), .rst(rst), .shift_en(in_valid), .restart(restart),
        .din(in_sample), .hist(hist), .full(full)
    );

    deconv3_coefs u_coefs (.sel(rate), .w(w));

    deconv3_mac u_mac (.newest(in_sample), .hist(hist), .w(w), .acc(acc), .y(y));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_sample <= y;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    // R5
    out_after_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8
    idle_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    mode_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(xrate_sel) |=> !out_valid);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (acc <= ACC_W'(ACC_BOUND) && acc >= ACC_W'(-ACC_BOUND)));

endmodule

// File: tb/deconv3_filter_tb.sv
module deconv3_filter_tb;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              xrate_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_sample = '0;
    logic              out_valid;
    logic signed [9:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    deconv3_filter u_dut (
        .clk(clk), .rst(rst), .xrate_sel(xrate_sel), .in_valid(in_valid),
        .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample)
    );

    // mode, oldest, middle, newest, expected
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{0, 100, 100, 100,   40},   // R2 flat
        '{1, 100, 100, 100,   16},   // R3 flat
        '{0,   0,   0, 255,  255},   // R2 newest tap
        '{1,   0, 255,   0, -309},   // R3 middle tap
        '{1, 255,   0, 255,  350},   // R3 outer taps
        '{0, 255, 255,   0, -152},   // R2 older taps
        '{0,   0, 128, 100,    6},   // R4 +5.5
        '{0,   0, 128,   0,  -94}    // R4 -94.5
    };

    function automatic int ref_out(int m, int a, int b, int c);
        int acc, r;
        acc = 256 * c + (m != 0 ? -310 : -189) * b + (m != 0 ? 95 : 36) * a;
        r = (acc + 128) >>> 8;
        if (r > 511)  r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(int s);
        in_valid = 1'b1; in_sample = 8'(s);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_test(int m);
        int s[16];
        int outs[16];
        int peak, pk_i, other;
        real x, step;
        step = (m != 0) ? 0.5 : 1.0;
        for (int k = 0; k < 16; k++) begin
            x = (k < 2) ? 0.0 : (k - 2) * step;
            s[k] = $rtoi(200.0 * x * $exp(1.0 - x) + 0.5);
        end
        do_reset();
        xrate_sel = m[0];
        @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            push(s[k]);
            if (k >= 2) begin
                outs[k] = int'(out_sample);
                check(out_valid && outs[k] == ref_out(m, s[k-2], s[k-1], s[k]),
                      m != 0 ? "R3 pulse" : "R2 pulse", outs[k], ref_out(m, s[k-2], s[k-1], s[k]));
            end else outs[k] = 0;
        end
        peak = 0; pk_i = 0;
        for (int k = 2; k < 16; k++)
            if ((outs[k] < 0 ? -outs[k] : outs[k]) > peak) begin
                peak = (outs[k] < 0 ? -outs[k] : outs[k]); pk_i = k;
            end
        other = 0;
        for (int k = 2; k < 16; k++)
            if (k != pk_i && (outs[k] < 0 ? -outs[k] : outs[k]) > other)
                other = (outs[k] < 0 ? -outs[k] : outs[k]);
        // R10 concentration
        check(peak >= 150 && other * 8 <= peak, "R10 concentration", other, peak / 8);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(!out_valid && out_sample == 0, "R1", int'(out_sample), 0);

        // table walk: each vector in a fresh window
        for (int i = 0; i < NV; i++) begin
            do_reset();
            xrate_sel = VEC[i][0][0];
            @(negedge clk);
            push(VEC[i][1]);
            push(VEC[i][2]);
            push(VEC[i][3]);
            // R5 result one clock after completing sample
            check(out_valid && int'(out_sample) == VEC[i][4], "R2/R3/R4 R5 vector",
                  int'(out_sample), VEC[i][4]);
            check(out_sample >= -512 && out_sample <= 511, "R9 range", int'(out_sample), 0);
        end

        // R6 warm-up after reset
        do_reset();
        xrate_sel = 1'b0;
        push(10);
        check(!out_valid, "R6 first", int'(out_valid), 0);
        push(20);
        check(!out_valid, "R6 second", int'(out_valid), 0);
        push(30);
        check(out_valid && int'(out_sample) == ref_out(0, 10, 20, 30), "R6 third",
              int'(out_sample), ref_out(0, 10, 20, 30));
        // R5 single-cycle pulse, R8 gaps
        idle();
        check(!out_valid, "R5 one cycle", int'(out_valid), 0);
        idle(); idle();
        check(!out_valid, "R8 idle", int'(out_valid), 0);
        push(200);
        check(out_valid && int'(out_sample) == ref_out(0, 20, 30, 200), "R8 no shift in gap",
              int'(out_sample), ref_out(0, 20, 30, 200));

        // R7 mode change mid-stream
        push(50);
        check(out_valid, "R7 pre-change stream", int'(out_valid), 1);
        xrate_sel = 1'b1;
        push(60);
        check(!out_valid, "R7 change sample", int'(out_valid), 0);
        push(70);
        check(!out_valid, "R7 second new", int'(out_valid), 0);
        push(80);
        check(out_valid && int'(out_sample) == ref_out(1, 60, 70, 80), "R7 third new",
              int'(out_sample), ref_out(1, 60, 70, 80));

        // R9 saturation boundary at the extremes
        do_reset();
        xrate_sel = 1'b1;
        @(negedge clk);
        push(255); push(0); push(255);
        check(out_valid && int'(out_sample) == ref_out(1, 255, 0, 255), "R9 max positive",
              int'(out_sample), ref_out(1, 255, 0, 255));

        pulse_test(0);
        pulse_test(1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule